// File: doc/BRIEF.md
# UART Transmitter with CTS Gating and Break

This block turns characters held in a transmit FIFO into an asynchronous serial frame. A frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts 16 pulses of the oversampling tick input. The FIFO is outside the block, which reads it through a first-word-fall-through port: it sees the head entry and an empty flag, and it pulses a pop strobe in the cycle it takes a character. The frame format is captured when a character starts, so a change to the line-control inputs takes effect from the next character.

Three controls decide whether a new character may start. A transmit-disable input holds characters back. A gate-enable input makes each start wait for the clear-to-send input, and a deassertion during a character does not cut that character short. A break input forces the line low for as long as it is held. A status output reports when the FIFO is empty and the last stop bit has left the shifter. A second status output reports the synchronized clear-to-send level.

Top module: `serial_tx_unit`

## Requirements
- R1: A character starts with one low start bit and sends its data bits least significant bit first, each bit 16 ticks long. With `modeSel` code 1 there are 7 data bits. With any other code (0 is the normal setting) there are 8. The line idles high.
- R2: With `parityOn` set, one parity bit follows the data bits. With `parityEven` set, the number of ones in the data bits and the parity bit together is even. With `parityEven` clear, that number is odd.
- R3: With `twoStop` clear, the frame ends with one high stop bit. With it set, the frame ends with two high stop bits. The next start bit can follow at the next tick after the last stop bit.
- R4: `fifoPop` is pulsed for exactly one cycle per character sent, and only while `fifoEmpty` is low.
- R5: While `ctsGateEn` is high and `ctsN` is high, no new character starts. `ctsStatus` shows `ctsN` after two clock cycles of synchronization, so 1 means clear-to-send is deasserted. With `ctsGateEn` low, `ctsN` has no effect on sending.
- R6: If `ctsN` rises while a character is being sent, that character still completes in full.
- R7: From the cycle after `breakOn` is sampled high, `txd` is low for as long as `breakOn` stays high. The line returns to its normal value one cycle after `breakOn` falls.
- R8: While `txDisable` is high, no new character starts and the FIFO is not popped.
- R9: `allSent` is 1 only when `fifoEmpty` is high and no character is in the shifter, including its final stop bit.
- R10: After reset, `txd` is high, no pop occurs, and `ctsStatus` is 1 until the synchronizer has sampled `ctsN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling tick, 16 per bit |
| fifoEmpty | input | 1 | Transmit FIFO is empty |
| fifoData | input | 8 | Head entry of the transmit FIFO |
| fifoPop | output | 1 | Take the head entry of the FIFO |
| modeSel | input | 2 | Data length code (1 = 7 bits, otherwise 8 bits) |
| parityOn | input | 1 | Append a parity bit |
| parityEven | input | 1 | 1 = even parity, 0 = odd parity |
| twoStop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| ctsGateEn | input | 1 | Make each start wait for clear-to-send |
| ctsN | input | 1 | Clear-to-send, active low |
| breakOn | input | 1 | Force the serial line low |
| txDisable | input | 1 | Hold back new characters |
| txd | output | 1 | Serial output |
| allSent | output | 1 | FIFO empty and shifter idle |
| ctsStatus | output | 1 | Synchronized `ctsN` (1 = deasserted) |

## Verification
The assertions check on every cycle that a pop happens only when the FIFO holds data, the transmitter is enabled and the gate permits it. They also check that a start bit follows each pop, that break drives the line low, and that `allSent` never claims completion while data is pending or right after a pop. Only the bench scenarios can show the content of a frame: the bit order, the 7-bit truncation, the parity sense and the number of stop bits. The bench rebuilds each frame from the line and compares it with a frame computed from the pushed byte. The bench scenarios also show that a character interrupted by a clear-to-send deassertion is still sent whole, and that held-back characters stay in the FIFO.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;   // capture head of FIFO into the shifter
    logic     shift;  // advance to the next data bit
    txState_e line;   // which source drives the line
  } txStrobe_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      fifoEmpty,
  input  logic      txDisable,
  input  logic      ctsGateEn,
  input  logic      ctsHigh,
  input  logic [1:0] modeSel,
  input  logic      parityOn,
  input  logic      twoStop,
  output logic      fifoPop,
  output txStrobe_t strobe,
  output logic      busy
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] CNT_LAST  = CW'(OVERSAMPLE - 1);
  localparam logic [IW-1:0] IDX_FULL  = IW'(DATA_W - 1);
  localparam logic [IW-1:0] IDX_SHORT = IW'(DATA_W - 2);

  txState_e      state;
  logic [CW-1:0] tickCnt;
  logic [IW-1:0] bitIdx;
  logic [IW-1:0] lastIdx;
  logic          parQ;
  logic          twoQ;
  logic          secondStop;

  logic canStart;
  logic bitEnd;
  logic launch;

  assign canStart = !fifoEmpty && !txDisable && !(ctsGateEn && ctsHigh);
  assign bitEnd   = tick && (tickCnt == CNT_LAST);
  assign launch   = (state == ST_IDLE) && tick && canStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tickCnt    <= '0;
      bitIdx     <= '0;
      lastIdx    <= IDX_FULL;
      parQ       <= 1'b0;
      twoQ       <= 1'b0;
      secondStop <= 1'b0;
    end else begin
      if (state == ST_IDLE) begin
        tickCnt <= '0;
      end else if (tick) begin
        tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      end

      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            state      <= ST_START;
            lastIdx    <= (modeSel == 2'd1) ? IDX_SHORT : IDX_FULL;
            parQ       <= parityOn;
            twoQ       <= twoStop;
            secondStop <= 1'b0;
          end
        end
        ST_START: begin
          if (bitEnd) begin
            state  <= ST_DATA;
            bitIdx <= '0;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            if (bitIdx == lastIdx) begin
              state <= parQ ? ST_PARITY : ST_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        ST_PARITY: begin
          if (bitEnd) state <= ST_STOP;
        end
        ST_STOP: begin
          if (bitEnd) begin
            if (twoQ && !secondStop) secondStop <= 1'b1;
            else                     state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = launch;
    strobe.shift = (state == ST_DATA) && bitEnd;
    strobe.line  = state;
  end

  assign fifoPop = launch;
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] fifoData,
  input  logic [1:0]        modeSel,
  input  logic              parityEven,
  input  logic              breakOn,
  input  logic              ctsN,
  output logic              txd,
  output logic              ctsHigh
);
  localparam logic [DATA_W-1:0] MASK_SHORT = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0]      shiftReg;
  logic                   parBit;
  logic [DATA_W-1:0]      dataMasked;
  logic                   lineBit;
  logic [SYNC_STAGES-1:0] syncQ;

  assign dataMasked = (modeSel == 2'd1) ? (fifoData & MASK_SHORT) : fifoData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= dataMasked;
      parBit   <= parityEven ? (^dataMasked) : ~(^dataMasked);
    end else if (strobe.shift) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    unique case (strobe.line)
      ST_START:  lineBit = 1'b0;
      ST_DATA:   lineBit = shiftReg[0];
      ST_PARITY: lineBit = parBit;
      default:   lineBit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txd <= 1'b1;
    else       txd <= breakOn ? 1'b0 : lineBit;
  end

  // clear-to-send synchronizer, resets to the deasserted level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= ctsN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ctsN};
      end
    end
  endgenerate

  assign ctsHigh = syncQ[SYNC_STAGES-1];

endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoPop,
  input  logic [1:0]        modeSel,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              twoStop,
  input  logic              ctsGateEn,
  input  logic              ctsN,
  input  logic              breakOn,
  input  logic              txDisable,
  output logic              txd,
  output logic              allSent,
  output logic              ctsStatus
);
  txStrobe_t strobe;
  logic      ctsHigh;
  logic      busy;

  sertx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .fifoEmpty(fifoEmpty),
    .txDisable(txDisable), .ctsGateEn(ctsGateEn), .ctsHigh(ctsHigh),
    .modeSel(modeSel), .parityOn(parityOn), .twoStop(twoStop),
    .fifoPop(fifoPop), .strobe(strobe), .busy(busy)
  );

  sertx_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fifoData(fifoData),
    .modeSel(modeSel), .parityEven(parityEven), .breakOn(breakOn),
    .ctsN(ctsN), .txd(txd), .ctsHigh(ctsHigh)
  );

  assign ctsStatus = ctsHigh;
  assign allSent   = fifoEmpty && !busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
  input logic clk,
  input logic rstN,
  input logic fifoEmpty,
  input logic fifoPop,
  input logic txd,
  input logic allSent,
  input logic breakOn,
  input logic txDisable,
  input logic ctsGateEn,
  input logic ctsStatus
);
  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  assert_start_after_pop_R1: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> ##1 !txd);

  assert_cts_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !(ctsGateEn && ctsStatus));

  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    breakOn |=> !txd);

  assert_disable_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !txDisable);

  assert_sent_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    allSent |-> fifoEmpty);

  assert_busy_after_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !allSent);
endmodule

bind serial_tx_unit sertx_checker u_chk (.*);

// File: tb/serial_tx_unit_test.sv
module serial_tx_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick;
  logic fifoEmpty, fifoPop, txd, allSent, ctsStatus;
  logic [7:0] fifoData;
  logic [1:0] modeSel = 2'd0;
  logic parityOn = 0, parityEven = 0, twoStop = 0;
  logic ctsGateEn = 0, ctsN = 1, breakOn = 0, txDisable = 1;

  int tickDiv = 1;
  int divCnt = 0;
  int testCount = 0, failCount = 0;

  // bench FIFO model, 8 entries
  logic [7:0] fmem [8];
  int fCount = 0, fRd = 0, fWr = 0, badPop = 0, popTotal = 0;
  logic pushReq = 0;
  logic [7:0] pushVal = 0;
  logic [15:0] expWord [512];
  int expWr = 0;

  // receiver results
  logic rxOn = 1, rxBusy = 0;
  logic [15:0] rxGot [512];
  int rxCount = 0, chkIdx = 0, lowCount = 0;

  serial_tx_unit uut (
    .clk(clk), .rstN(rstN), .tick(tick), .fifoEmpty(fifoEmpty),
    .fifoData(fifoData), .fifoPop(fifoPop), .modeSel(modeSel),
    .parityOn(parityOn), .parityEven(parityEven), .twoStop(twoStop),
    .ctsGateEn(ctsGateEn), .ctsN(ctsN), .breakOn(breakOn),
    .txDisable(txDisable), .txd(txd), .allSent(allSent), .ctsStatus(ctsStatus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (divCnt >= tickDiv - 1) divCnt <= 0;
    else divCnt <= divCnt + 1;
  end
  assign tick = (divCnt == 0);

  assign fifoEmpty = (fCount == 0);
  assign fifoData  = fmem[fRd];

  function automatic int frameLen();
    return 1 + ((modeSel == 2'd1) ? 7 : 8) + (parityOn ? 1 : 0) + (twoStop ? 2 : 1);
  endfunction

  function automatic logic [15:0] expFrame(input logic [7:0] b);
    logic [15:0] w;
    logic [7:0] d;
    int k;
    int nd;
    nd = (modeSel == 2'd1) ? 7 : 8;
    d = (modeSel == 2'd1) ? (b & 8'h7f) : b;
    w = '0;
    k = 1;
    for (int i = 0; i < nd; i++) begin w[k] = d[i]; k++; end
    if (parityOn) begin w[k] = parityEven ? (^d) : ~(^d); k++; end
    w[k] = 1'b1; k++;
    if (twoStop) w[k] = 1'b1;
    return w;
  endfunction

  always @(posedge clk) begin
    if (fifoPop) begin
      popTotal++;
      if (fCount == 0) badPop++;
      else begin fRd = (fRd + 1) % 8; fCount--; end
    end
    if (pushReq && fCount < 8) begin
      fmem[fWr] = pushVal;
      fWr = (fWr + 1) % 8;
      fCount++;
      expWord[expWr] = expFrame(pushVal);
      expWr++;
    end
  end

  always @(negedge clk) if (txd === 1'b0) lowCount++;

  // line receiver: rebuild each frame bit by bit at mid-bit
  initial begin
    forever begin
      @(negedge clk);
      if (rxOn && rstN && txd === 1'b0) begin
        logic [15:0] word;
        int bc;
        int len;
        rxBusy = 1;
        bc = 16 * tickDiv;
        len = frameLen();
        word = '0;
        repeat (bc / 2) @(negedge clk);
        word[0] = txd;
        for (int k = 1; k < len; k++) begin
          repeat (bc) @(negedge clk);
          word[k] = txd;
        end
        rxGot[rxCount] = word;
        rxCount++;
        rxBusy = 0;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCount + 1, failCount + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    while (fCount >= 8) @(negedge clk);
    pushVal = v;
    pushReq = 1;
    @(negedge clk);
    pushReq = 0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!(fCount == 0 && allSent && !rxBusy));
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFrames();
    check(rxCount == expWr, "R4 one frame per pushed byte", rxCount, expWr);
    while (chkIdx < rxCount && chkIdx < expWr) begin
      check(rxGot[chkIdx] == expWord[chkIdx], "R1 R2 R3 frame content", rxGot[chkIdx], expWord[chkIdx]);
      chkIdx++;
    end
  endtask

  initial begin
    int snap;
    int rxSnap;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(txd == 1'b1, "R10 idle line after reset", txd, 1);
    check(allSent == 1'b1, "R10 R9 allSent after reset", allSent, 1);
    check(ctsStatus == 1'b1, "R10 ctsStatus reset", ctsStatus, 1);
    check(popTotal == 0, "R10 no pop after reset", popTotal, 0);

    // transmit disabled: byte must wait
    snap = lowCount;
    push(8'hA5);
    repeat (200) @(negedge clk);
    check(lowCount == snap, "R8 line quiet while disabled", lowCount - snap, 0);
    check(fCount == 1, "R8 byte kept in FIFO", fCount, 1);
    check(allSent == 1'b0, "R9 allSent low with FIFO data", allSent, 0);
    txDisable = 0;
    waitIdle();
    checkFrames();

    // directed formats
    modeSel = 2'd1; push(8'hFF); waitIdle(); checkFrames();          // R1 7-bit drop
    modeSel = 2'd0; parityOn = 1; parityEven = 1; push(8'h00); push(8'h01); waitIdle(); checkFrames(); // R2
    parityEven = 0; push(8'h00); push(8'h03); waitIdle(); checkFrames();
    twoStop = 1; push(8'h5A); push(8'hC3); push(8'h0F); waitIdle(); checkFrames(); // R3 back to back
    twoStop = 0; parityOn = 0; modeSel = 2'd3; push(8'h80); waitIdle(); checkFrames(); // R1 code 3 is 8 bits

    // allSent stays low during the last character
    modeSel = 2'd0;
    push(8'h3C);
    wait (rxBusy);
    repeat (40) @(negedge clk);
    check(fCount == 0 && allSent == 1'b0, "R9 allSent low while shifting", allSent, 0);
    waitIdle();
    check(allSent == 1'b1, "R9 allSent high after stop bit", allSent, 1);
    checkFrames();

    // clear-to-send gating
    ctsGateEn = 1; ctsN = 1;
    snap = lowCount;
    push(8'h11); push(8'h22);
    repeat (300) @(negedge clk);
    check(lowCount == snap && fCount == 2, "R5 gated start held", fCount, 2);
    check(ctsStatus == 1'b1, "R5 status deasserted", ctsStatus, 1);
    rxSnap = rxCount;
    ctsN = 0;
    repeat (3) @(negedge clk);
    check(ctsStatus == 1'b0, "R5 status asserted", ctsStatus, 0);
    wait (rxBusy);
    repeat (48) @(negedge clk);
    ctsN = 1;
    wait (rxCount == rxSnap + 1);
    repeat (200) @(negedge clk);
    check(fCount == 1, "R6 next byte held after mid-frame drop", fCount, 1);
    check(rxGot[rxSnap] == expWord[rxSnap], "R6 interrupted frame complete", rxGot[rxSnap], expWord[rxSnap]);
    ctsN = 0;
    waitIdle();
    checkFrames();
    ctsGateEn = 0; ctsN = 1;
    push(8'h77); waitIdle(); checkFrames();  // R5 gate off ignores ctsN

    // break
    rxOn = 0;
    breakOn = 1;
    @(negedge clk);
    snap = lowCount;
    repeat (100) @(negedge clk);
    check(lowCount - snap == 100, "R7 line low during break", lowCount - snap, 100);
    breakOn = 0;
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R7 line released", txd, 1);
    rxOn = 1;

    // random formats and traffic
    for (int b = 0; b < 12; b++) begin
      int n;
      modeSel = 2'($urandom % 4);
      parityOn = 1'($urandom % 2);
      parityEven = 1'($urandom % 2);
      twoStop = 1'($urandom % 2);
      tickDiv = (b >= 8) ? 2 : 1;
      n = 1 + ($urandom % 8);
      for (int i = 0; i < n; i++) push(8'($urandom));
      waitIdle();
      checkFrames();
    end

    check(badPop == 0, "R4 no pop on empty FIFO", badPop, 0);
    check(popTotal == expWr, "R4 pop count", popTotal, expWr);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule